// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that executes a subset of a classic load/store instruction set and retires one instruction on every clock edge. Register-to-register arithmetic and logic, word loads, word stores and a branch-if-equal are supported. The program counter, a 32-entry register file and a word-addressed data memory are the only state. Everything between them (decode, operand selection, ALU, address and next-PC computation) settles combinationally within the cycle.

Control is split across two levels. A main decoder looks only at the opcode and produces the datapath strobes plus a two-bit operation class. A second decoder turns that class, together with the function field for register-type instructions, into a four-bit ALU operation code. Both memories live inside the core. While reset is held, the surrounding logic fills them through a simple load port. A debug read port exposes any register for observation.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0 and every register is cleared to 0 at that edge. The memory load port stays usable during reset.
- R2: Opcode 0 (register type) writes `rs op rt` into register `rd` (bits [15:11]). The funct field (bits [5:0]) selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-on-less-than.
- R3: Opcode 35 (bits [31:26]) loads into `rt` (bits [20:16]) the data word at byte address `rs + signext(imm16)`. `rs` is bits [25:21], the immediate is bits [15:0], and the word index is address bits [7:2] for the default 64-word memory.
- R4: Opcode 43 stores `rt` to the data word at `rs + signext(imm16)` and writes no register. A later load from that address returns the stored value.
- R5: Set-on-less-than compares signed values and writes exactly 1 or 0.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: Opcode 4 compares `rs` and `rt`. When they are equal the next PC is `PC + 4 + (signext(imm16) << 2)`. Otherwise it is `PC + 4`. Negative offsets branch backwards.
- R8: An unrecognised opcode, or a register-type instruction with an unrecognised funct, changes no register and no memory word and only advances the PC by 4.
- R9: Each instruction completes in one cycle. Except for a taken branch, the PC advances by exactly 4 on every clock edge after reset.
- R10: The ALU operation code is 0010 (add) for loads and stores, 0110 (subtract) for branches, and for register-type instructions it follows the funct field. The encoding is 0000 AND, 0001 OR, 0010 add, 0110 subtract, 0111 set-on-less-than, 1100 NOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high; holds the core idle |
| loadImem | input | 1 | Writes `loadData` into instruction word `loadAddr` |
| loadDmem | input | 1 | Writes `loadData` into data word `loadAddr` |
| loadAddr | input | LOAD_AW | Word index for the load port |
| loadData | input | 32 | Word written by the load port |
| pc | output | 32 | Current program counter (byte address) |
| dbgAddr | input | 5 | Register number for the debug read port |
| dbgData | output | 32 | Combinational contents of register `dbgAddr` |

## Verification
On every cycle, the assertions check the following: the PC step of 4 on non-branch cycles, the exact branch target after a taken branch, the PC after reset, and the ALU code forced by loads, stores and branches. They also check that stores and unknown encodings raise no write strobe, and that register 0 reads as zero. The bench scenarios are the only way to show data values. These include arithmetic results, signed comparison, a store followed by a load, skipped instructions after a taken branch, and the fact that invalid encodings leave registers untouched. A behavioural instruction-level model is stepped alongside the core and compared on every cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREGS = 32;
  localparam int RAW = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } aluCtlE;

  typedef enum logic [1:0] {
    AOP_MEM   = 2'b00,
    AOP_BR    = 2'b01,
    AOP_FUNCT = 2'b10
  } aluOpE;

  typedef struct packed {
    logic   regDst;
    logic   aluSrc;
    logic   memToReg;
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    aluOpE  aluOp;
    aluCtlE aluCtl;
  } ctrlT;
endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlT       ctrl
);
  logic   mainRegWrite;
  logic   functOk;
  aluOpE  opClass;
  aluCtlE opCode;

  // first level: opcode only
  always_comb begin
    ctrl.regDst   = 1'b0;
    ctrl.aluSrc   = 1'b0;
    ctrl.memToReg = 1'b0;
    mainRegWrite  = 1'b0;
    ctrl.memRead  = 1'b0;
    ctrl.memWrite = 1'b0;
    ctrl.branch   = 1'b0;
    opClass       = AOP_MEM;
    case (opcode)
      OP_RTYPE: begin
        ctrl.regDst  = 1'b1;
        mainRegWrite = 1'b1;
        opClass      = AOP_FUNCT;
      end
      OP_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        mainRegWrite  = 1'b1;
        ctrl.memRead  = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        opClass     = AOP_BR;
      end
      default: ;
    endcase
  end

  // second level: class plus funct
  always_comb begin
    functOk = 1'b1;
    opCode  = ALU_ADD;
    case (opClass)
      AOP_MEM: opCode = ALU_ADD;
      AOP_BR:  opCode = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  opCode = ALU_ADD;
          FN_SUB:  opCode = ALU_SUB;
          FN_AND:  opCode = ALU_AND;
          FN_OR:   opCode = ALU_OR;
          FN_SLT:  opCode = ALU_SLT;
          default: begin
            opCode  = ALU_AND;
            functOk = 1'b0;
          end
        endcase
      end
      default: functOk = 1'b0;
    endcase
  end

  assign ctrl.regWrite = mainRegWrite & functOk;
  assign ctrl.aluOp    = opClass;
  assign ctrl.aluCtl   = opCode;
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  aluCtlE       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_AND: result = a & b;
      ALU_OR:  result = a | b;
      ALU_ADD: result = a + b;
      ALU_SUB: result = a - b;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: result = ~(a | b);
      default: result = '0;
    endcase
  end
  assign zero = (result == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RAW-1:0] rdAddrA,
  input  logic [RAW-1:0] rdAddrB,
  input  logic [RAW-1:0] rdAddrDbg,
  output logic [W-1:0]   rdDataA,
  output logic [W-1:0]   rdDataB,
  output logic [W-1:0]   rdDataDbg,
  input  logic           wrEn,
  input  logic [RAW-1:0] wrAddr,
  input  logic [W-1:0]   wrData
);
  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA   = (rdAddrA   == '0) ? '0 : regs[rdAddrA];
  assign rdDataB   = (rdAddrB   == '0) ? '0 : regs[rdAddrB];
  assign rdDataDbg = (rdAddrDbg == '0) ? '0 : regs[rdAddrDbg];
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlT               ctrl,
  input  logic               loadImem,
  input  logic               loadDmem,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]    loadData,
  input  logic [RAW-1:0]     dbgAddr,
  output logic [XLEN-1:0]    dbgData,
  output logic [XLEN-1:0]    pc,
  output logic [XLEN-1:0]    instr,
  output logic               pcSrc
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [RAW-1:0]  rsF, rtF, rdF, wrReg;
  logic [15:0]     immF;
  logic [XLEN-1:0] immExt, rsVal, rtVal, aluB, aluOut, memRd, wbVal;
  logic [XLEN-1:0] pcPlus4, brTarget, pcNext;
  logic            aluZero;

  // fetch
  assign instr = imem[pc[IAW+1:2]];
  assign rsF   = instr[25:21];
  assign rtF   = instr[20:16];
  assign rdF   = instr[15:11];
  assign immF  = instr[15:0];

  assign immExt = {{(XLEN-16){immF[15]}}, immF};

  sc_regfile #(.W(XLEN)) regFile (
    .clk      (clk),
    .rst      (rst),
    .rdAddrA  (rsF),
    .rdAddrB  (rtF),
    .rdAddrDbg(dbgAddr),
    .rdDataA  (rsVal),
    .rdDataB  (rtVal),
    .rdDataDbg(dbgData),
    .wrEn     (ctrl.regWrite && !rst),
    .wrAddr   (wrReg),
    .wrData   (wbVal)
  );

  assign wrReg = ctrl.regDst ? rdF : rtF;
  assign aluB  = ctrl.aluSrc ? immExt : rtVal;

  sc_alu #(.W(XLEN)) alu (
    .op    (ctrl.aluCtl),
    .a     (rsVal),
    .b     (aluB),
    .result(aluOut),
    .zero  (aluZero)
  );

  // data memory
  assign memRd = ctrl.memRead ? dmem[aluOut[DAW+1:2]] : '0;
  assign wbVal = ctrl.memToReg ? memRd : aluOut;

  always_ff @(posedge clk) begin
    if (loadDmem) dmem[loadAddr[DAW-1:0]] <= loadData;
    else if (ctrl.memWrite && !rst) dmem[aluOut[DAW+1:2]] <= rtVal;
  end

  always_ff @(posedge clk) begin
    if (loadImem) imem[loadAddr[IAW-1:0]] <= loadData;
  end

  // next PC
  assign pcPlus4  = pc + XLEN'(4);
  assign brTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign pcSrc    = ctrl.branch & aluZero;
  assign pcNext   = pcSrc ? brTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  logic unusedBits;
  assign unusedBits = ^{instr[10:6], pc[1:0], aluOut[1:0], aluOut[XLEN-1:DAW+2],
                        pc[XLEN-1:IAW+2], loadAddr};
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadImem,
  input  logic               loadDmem,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  output logic [31:0]        pc,
  input  logic [4:0]         dbgAddr,
  output logic [31:0]        dbgData
);
  ctrlT        ctrlW;
  logic [31:0] instrW;
  logic        pcSrcW;

  sc_control ctl (
    .opcode(instrW[31:26]),
    .funct (instrW[5:0]),
    .ctrl  (ctrlW)
  );

  sc_datapath #(
    .IMEM_WORDS(IMEM_WORDS),
    .DMEM_WORDS(DMEM_WORDS),
    .LOAD_AW   (LOAD_AW)
  ) dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrlW),
    .loadImem(loadImem),
    .loadDmem(loadDmem),
    .loadAddr(loadAddr),
    .loadData(loadData),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData),
    .pc      (pc),
    .instr   (instrW),
    .pcSrc   (pcSrcW)
  );
endmodule

// File: rtl/sc_core_checker.sv
module sc_core_checker
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input ctrlT        ctrl,
  input logic        pcSrc,
  input logic [4:0]  dbgAddr,
  input logic [31:0] dbgData
);
  logic [31:0] brOff;
  logic [5:0]  opF;
  logic        knownOp;
  assign brOff   = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign opF     = instr[31:26];
  assign knownOp = (opF == OP_RTYPE) || (opF == OP_LOAD) || (opF == OP_STORE) || (opF == OP_BEQ);

  AST_PC_RESET: assert property (@(posedge clk) rst |=> pc == 32'd0); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !pcSrc |=> pc == $past(pc) + 32'd4); // R9
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    pcSrc |=> pc == $past(pc) + 32'd4 + $past(brOff)); // R7
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    opF == OP_STORE |-> !ctrl.regWrite && ctrl.memWrite); // R4
  AST_MEM_ADDS: assert property (@(posedge clk) disable iff (rst)
    (opF == OP_LOAD || opF == OP_STORE) |-> ctrl.aluCtl == ALU_ADD); // R10
  AST_BEQ_SUBS: assert property (@(posedge clk) disable iff (rst)
    opF == OP_BEQ |-> ctrl.aluCtl == ALU_SUB && !ctrl.regWrite); // R7
  AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> !ctrl.regWrite && !ctrl.memWrite && !ctrl.branch && !pcSrc); // R8
  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    dbgAddr == 5'd0 |-> dbgData == 32'd0); // R6
endmodule

bind sc_core sc_core_checker chk (
  .clk    (clk),
  .rst    (rst),
  .pc     (pc),
  .instr  (instrW),
  .ctrl   (ctrlW),
  .pcSrc  (pcSrcW),
  .dbgAddr(dbgAddr),
  .dbgData(dbgData)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadImem = 1'b0;
  logic        loadDmem = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [31:0] pc;
  logic [4:0]  dbgAddr = '0;
  logic [31:0] dbgData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .loadImem(loadImem), .loadDmem(loadDmem),
    .loadAddr(loadAddr), .loadData(loadData), .pc(pc),
    .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  // behavioural reference state
  logic [31:0] mImem [64];
  logic [31:0] mDmem [64];
  logic [31:0] mReg [32];
  logic [31:0] mPc;

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic resetModel();
    mPc = 0;
    for (int i = 0; i < 32; i++) mReg[i] = 0;
  endtask

  task automatic stepModel();
    logic [31:0] ins, a, b, sx, res, addr, nxt;
    logic [5:0] op, fn;
    int rs, rt, rd;
    bit ok;
    ins = mImem[mPc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = mReg[rs]; b = mReg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    addr = a + sx;
    nxt = mPc + 4;
    ok = 1;
    res = 0;
    case (op)
      6'd0: begin
        case (fn)
          6'd32: res = a + b;
          6'd34: res = a - b;
          6'd36: res = a & b;
          6'd37: res = a | b;
          6'd42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: ok = 0;
        endcase
        if (ok && rd != 0) mReg[rd] = res;
      end
      6'd35: if (rt != 0) mReg[rt] = mDmem[addr[7:2]];
      6'd43: mDmem[addr[7:2]] = b;
      6'd4:  if (a == b) nxt = mPc + 4 + (sx << 2);
      default: ;
    endcase
    mPc = nxt;
  endtask

  task automatic peekReg(int idx, logic [31:0] exp, string tag);
    @(negedge clk);
    dbgAddr = 5'(idx);
    #1;
    check(tag, dbgData, exp);
  endtask

  initial begin
    // program
    for (int i = 0; i < 64; i++) mImem[i] = 32'd0;
    mImem[0]  = encI(6'd35, 0, 1, 16'd0);        // r1 = 5
    mImem[1]  = encI(6'd35, 0, 2, 16'd4);        // r2 = -3
    mImem[2]  = encR(1, 2, 3, 6'b100000);        // add
    mImem[3]  = encR(2, 1, 4, 6'b100010);        // sub
    mImem[4]  = encR(1, 2, 5, 6'b100100);        // and
    mImem[5]  = encR(1, 2, 6, 6'b100101);        // or
    mImem[6]  = encR(2, 1, 7, 6'b101010);        // slt -3<5
    mImem[7]  = encR(1, 2, 8, 6'b101010);        // slt 5<-3
    mImem[8]  = encI(6'd43, 0, 4, 16'd8);        // store r4
    mImem[9]  = encI(6'd35, 0, 9, 16'd8);        // reload
    mImem[10] = encR(1, 1, 0, 6'b100000);        // write r0
    mImem[11] = encI(6'd4, 1, 2, 16'd5);         // not taken
    mImem[12] = encI(6'd4, 3, 3, 16'd2);         // taken -> 60
    mImem[13] = encR(1, 1, 10, 6'b100000);       // skipped
    mImem[14] = encR(1, 1, 10, 6'b100000);       // skipped
    mImem[15] = encI(6'h3F, 1, 13, 16'h0010);    // bad opcode
    mImem[16] = encR(1, 1, 12, 6'b000111);       // bad funct
    mImem[17] = encR(1, 1, 11, 6'b100000);       // r11 = 10
    mImem[18] = encI(6'd4, 0, 0, 16'hFFFF);      // loop on itself
    for (int i = 0; i < 64; i++) mDmem[i] = 32'(i * 3 + 100);
    mDmem[0] = 32'd5;
    mDmem[1] = 32'hFFFF_FFFD;

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      loadImem = 1; loadDmem = 0; loadAddr = 8'(i); loadData = mImem[i];
      @(negedge clk);
      loadImem = 0; loadDmem = 1; loadData = mDmem[i];
    end
    @(negedge clk);
    loadImem = 0; loadDmem = 0;
    resetModel();
    @(negedge clk);
    rst = 0;
    #1;
    check("R1 pc after reset", pc, 32'd0);
    dbgAddr = 5'd5; #1;
    check("R1 reg cleared", dbgData, 32'd0);

    for (int cyc = 0; cyc < 40; cyc++) begin
      @(posedge clk);
      stepModel();
      @(negedge clk);
      dbgAddr = 5'(cyc % 32);
      #1;
      check("R9 R7 pc vs model", pc, mPc);
      check("R2 R3 register vs model", dbgData, mReg[cyc % 32]);
    end

    peekReg(3,  32'd2,          "R2 add");
    peekReg(4,  32'hFFFF_FFF8,  "R2 sub");
    peekReg(5,  32'd5,          "R2 and");
    peekReg(6,  32'hFFFF_FFFD,  "R2 or");
    peekReg(7,  32'd1,          "R5 slt signed true");
    peekReg(8,  32'd0,          "R5 slt signed false");
    peekReg(1,  32'd5,          "R3 load");
    peekReg(9,  32'hFFFF_FFF8,  "R4 store then load");
    peekReg(0,  32'd0,          "R6 r0 stays zero");
    peekReg(10, 32'd0,          "R7 skipped after taken branch");
    peekReg(13, 32'd0,          "R8 bad opcode no write");
    peekReg(12, 32'd0,          "R8 bad funct no write");
    peekReg(11, 32'd10,         "R8 execution resumes");
    check("R7 backward branch holds pc", pc, 32'd72);

    // reset again mid-run
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    #1;
    check("R1 pc after second reset", pc, 32'd0);
    dbgAddr = 5'd3; #1;
    check("R1 reg cleared again", dbgData, 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule